// File: doc/BRIEF.md
# ULPI Transceiver Power-Up and Reset Sequencer

This block is the control core of a ULPI transceiver that decides when the ULPI bus can be used. It watches a power-good level, a chip-select input and a PLL-lock flag. All three pass through a level synchroniser of `SYNC_STAGES` flops. The block drives the bus direction signal, an enable for the 60 MHz output clock, the output enables of the ULPI pins and the self-clearing reset bit of the function-control register. It also sends a one-cycle request for a receive command (RXCMD) that carries the current line state.

The states are `ST_OFF` (powered down), `ST_PLL_WAIT` (bus held, waiting for the PLL), `ST_RESETTING` (internal reset timer running), `ST_RXCMD` (status report) and `ST_READY`. The transitions are:
- **power-on**: `ST_OFF` to `ST_PLL_WAIT`, when power-good and chip select are both high after synchronisation.
- **lock**: `ST_PLL_WAIT` to `ST_RESETTING`, when the synchronised PLL flag is high.
- **timeout**: `ST_RESETTING` to `ST_RXCMD`, when the timer expires.
- **report**: `ST_RXCMD` to `ST_READY`, always after one cycle.
- **soft-reset**: `ST_READY` to `ST_RESETTING`, while the reset bit is set.
- **drop**: any state to `ST_OFF`, when power or chip select goes away. This transition has the highest priority.

The link starts a soft reset by writing to the function-control register. The strobe `reg_wr` with `reg_addr` and `reg_wdata` is assumed to be decoded already. A power-on reset ends the same way as a soft reset: the timer expires, the direction signal falls and one RXCMD goes out.

Top module: `ulpi_pwr_seq`

## Requirements
- R1: While synchronised power-good or chip select is low (and during `rst_n` low), `pins_oe`, `dir`, `clk_out_en`, `rst_bit` and `rxcmd_req` are all 0. Loss of either input during a reset forces this state and clears `rst_bit`.
- R2: A register write presented while powered down leaves `rst_bit` at 0. After power returns, no soft reset follows from that write.
- R3: On leaving power-down, `pins_oe` and `dir` go to 1 while `clk_out_en` stays 0 until the synchronised PLL flag is high.
- R4: Once the PLL flag is seen, `clk_out_en` goes to 1 and `dir` stays 1 for exactly `RST_CYCLES` cycles (default 16) counted from that cycle, then falls.
- R5: A write with `reg_addr` = 0x04 and `reg_wdata` bit 5 = 1 in `ST_READY` sets `rst_bit` on the next cycle. `dir` rises the cycle after that and stays 1 for exactly `RST_CYCLES` cycles.
- R6: `rst_bit` returns to 0 in the same cycle in which `dir` falls at the end of a reset.
- R7: After every reset (power-on, soft or hardware) `rxcmd_req` is 1 for exactly one cycle, the first cycle with `dir` low. In that cycle `rxcmd_ls` equals the `line_state` input; at all other times it is 0.
- R8: A further reset write while a reset runs restarts the timer. `dir` then stays 1 for `RST_CYCLES` cycles after the cycle that took the write.
- R9: Writes to any other address, or to 0x04 with bit 5 = 0, change neither `rst_bit` nor `dir`.
- R10: Taking chip select low and then high again repeats the whole sequence: `dir` high with the clock off, then `RST_CYCLES` cycles of reset, then one RXCMD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply present (asynchronous level) |
| chip_sel | input | 1 | Chip select, high = active (asynchronous level) |
| pll_locked | input | 1 | PLL stable flag (asynchronous level) |
| reg_wr | input | 1 | Register write strobe from the link |
| reg_addr | input | 6 | Register address of the write |
| reg_wdata | input | 8 | Register write data |
| line_state | input | 2 | Current USB line state for the RXCMD |
| dir | output | 1 | Bus direction, 1 = bus owned by the transceiver |
| clk_out_en | output | 1 | Enable for the 60 MHz output clock |
| pins_oe | output | 1 | Output enable for ULPI pins, 0 = high impedance |
| rst_bit | output | 1 | Reset bit of the function-control register |
| rxcmd_req | output | 1 | One-cycle request to send an RXCMD |
| rxcmd_ls | output | 2 | Line-state field of the RXCMD |

## Verification
The bench measures the exact width of each `dir` pulse, after power-up, after a soft reset and after a reset that is re-triggered part-way. An off-by-one timer, or a timer that ignores the second write, would show up as a pulse one cycle or several cycles off. The bench also checks that the reset bit and the RXCMD pulse line up with the falling edge of `dir`. A design that cleared the bit late, or pulsed for two cycles, would fail there. Writes presented while powered down, and writes to other addresses or with bit 5 clear, must leave no pending reset. A design that latched such a write would raise `dir` again once power came back. Dropping power in the middle of a reset must clear the bit.

// File: rtl/ulpi_pwr_pkg.sv
package ulpi_pwr_pkg;

    // Function-control register location and its self-clearing reset bit
    localparam int FCTL_ADDR = 4;
    localparam int RESET_BIT = 5;

    typedef enum logic [2:0] {
        ST_OFF       = 3'd0,
        ST_PLL_WAIT  = 3'd1,
        ST_RESETTING = 3'd2,
        ST_RXCMD     = 3'd3,
        ST_READY     = 3'd4
    } pwr_state_e;

endpackage

// File: rtl/ulpi_pwr_sync.sv
module ulpi_pwr_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ulpi_rst_timer.sv
module ulpi_rst_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic done
);

    localparam int             CW   = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
    localparam logic [CW-1:0]  LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (!run || restart)  cnt <= '0;
        else if (cnt != LAST)      cnt <= cnt + 1'b1;
    end

    // A write landing in the last cycle wins over expiry
    assign done = run && !restart && (cnt == LAST);

endmodule

// File: rtl/ulpi_fctl_reset.sv
module ulpi_fctl_reset
    import ulpi_pwr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clear,
    output logic              rst_bit,
    output logic              hit
);

    localparam logic [DATA_W-1:0] RST_MASK = DATA_W'(1) << RESET_BIT;

    assign hit = accept && wr && (addr == ADDR_W'(FCTL_ADDR)) && |(wdata & RST_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rst_bit <= 1'b0;
        else if (!accept) rst_bit <= 1'b0;
        else if (hit)     rst_bit <= 1'b1;
        else if (clear)   rst_bit <= 1'b0;
    end

endmodule

// File: rtl/ulpi_pwr_fsm.sv
module ulpi_pwr_fsm
    import ulpi_pwr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic pll_ok,
    input  logic rst_req,
    input  logic tmr_done,
    output logic dir,
    output logic clk_en,
    output logic pins_oe,
    output logic rxcmd_req,
    output logic tmr_run,
    output logic rst_clear
);

    pwr_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:       if (supply_ok) state_nx = ST_PLL_WAIT;
            ST_PLL_WAIT:  if (pll_ok)    state_nx = ST_RESETTING;
            ST_RESETTING: if (tmr_done)  state_nx = ST_RXCMD;
            ST_RXCMD:                    state_nx = ST_READY;
            ST_READY:     if (rst_req)   state_nx = ST_RESETTING;
            default:                     state_nx = ST_OFF;
        endcase
        if (!supply_ok) state_nx = ST_OFF;
    end

    always_comb begin
        dir       = 1'b0;
        clk_en    = 1'b0;
        pins_oe   = 1'b1;
        rxcmd_req = 1'b0;
        tmr_run   = 1'b0;
        rst_clear = 1'b0;
        unique case (state)
            ST_OFF:       pins_oe = 1'b0;
            ST_PLL_WAIT:  dir = 1'b1;
            ST_RESETTING: begin
                dir       = 1'b1;
                clk_en    = 1'b1;
                tmr_run   = 1'b1;
                rst_clear = tmr_done;
            end
            ST_RXCMD: begin
                clk_en    = 1'b1;
                rxcmd_req = 1'b1;
            end
            ST_READY:     clk_en = 1'b1;
            default:      pins_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/ulpi_pwr_seq.sv
module ulpi_pwr_seq
    import ulpi_pwr_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int LS_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              chip_sel,
    input  logic              pll_locked,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [LS_W-1:0]   line_state,
    output logic              dir,
    output logic              clk_out_en,
    output logic              pins_oe,
    output logic              rst_bit,
    output logic              rxcmd_req,
    output logic [LS_W-1:0]   rxcmd_ls
);

    logic [2:0] lvl_sync;
    logic       supply_ok, pll_ok;
    logic       tmr_run, tmr_done, rst_clear, wr_hit, accept;

    ulpi_pwr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pll_locked, chip_sel, pwr_good}),
        .q     (lvl_sync)
    );

    assign supply_ok = lvl_sync[0] && lvl_sync[1];
    assign pll_ok    = lvl_sync[2];
    // Pins are ignored in power-down and on the edge that enters it
    assign accept    = supply_ok && pins_oe;

    ulpi_fctl_reset #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .clear   (rst_clear),
        .rst_bit (rst_bit),
        .hit     (wr_hit)
    );

    ulpi_rst_timer #(.CYCLES(RST_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .restart (wr_hit),
        .done    (tmr_done)
    );

    ulpi_pwr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .pll_ok    (pll_ok),
        .rst_req   (rst_bit),
        .tmr_done  (tmr_done),
        .dir       (dir),
        .clk_en    (clk_out_en),
        .pins_oe   (pins_oe),
        .rxcmd_req (rxcmd_req),
        .tmr_run   (tmr_run),
        .rst_clear (rst_clear)
    );

    assign rxcmd_ls = rxcmd_req ? line_state : '0;

endmodule

// File: rtl/ulpi_pwr_seq_chk.sv
module ulpi_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic dir,
    input logic clk_out_en,
    input logic pins_oe,
    input logic rst_bit,
    input logic rxcmd_req
);

    // R1
    pd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pins_oe |-> (!dir && !clk_out_en && !rst_bit && !rxcmd_req));

    // R3
    pll_wait_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_oe && !clk_out_en) |-> dir);

    // R4
    clk_start_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_out_en) |-> dir);

    // R6
    bit_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxcmd_req |-> !rst_bit);

    // R7
    rxcmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxcmd_req |=> !rxcmd_req);

    // R7
    rxcmd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dir) && pins_oe) |-> rxcmd_req);

endmodule

bind ulpi_pwr_seq ulpi_pwr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir        (dir),
    .clk_out_en (clk_out_en),
    .pins_oe    (pins_oe),
    .rst_bit    (rst_bit),
    .rxcmd_req  (rxcmd_req)
);

// File: tb/ulpi_pwr_seq_test.sv
module ulpi_pwr_seq_test;

    localparam int N    = 16;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_good = 1'b0, chip_sel = 1'b0, pll_locked = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [1:0] line_state = 2'b00;
    logic       dir, clk_out_en, pins_oe, rst_bit, rxcmd_req;
    logic [1:0] rxcmd_ls;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    ulpi_pwr_seq #(.RST_CYCLES(N), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .chip_sel(chip_sel),
        .pll_locked(pll_locked), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .line_state(line_state), .dir(dir),
        .clk_out_en(clk_out_en), .pins_oe(pins_oe), .rst_bit(rst_bit),
        .rxcmd_req(rxcmd_req), .rxcmd_ls(rxcmd_ls)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic measure_high(output int n);
        n = 0;
        while (dir === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_dir_high();
        for (int g = 0; g < 200 && dir !== 1'b1; g++) @(negedge clk);
    endtask

    task automatic wait_clk_on();
        for (int g = 0; g < 200 && clk_out_en !== 1'b1; g++) @(negedge clk);
    endtask

    // At the first dir-low cycle after a reset
    task automatic check_report(input string req);
        chk(req, "rxcmd_req at dir fall", int'(rxcmd_req), 1);
        chk(req, "rxcmd_ls", int'(rxcmd_ls), int'(line_state));
        chk("R6", "rst_bit at dir fall", int'(rst_bit), 0);
        @(negedge clk);
        chk("R7", "rxcmd_req second cycle", int'(rxcmd_req), 0);
        chk("R7", "rxcmd_ls idle", int'(rxcmd_ls), 0);
    endtask

    task automatic finish_power_up(input string req);
        int n;
        wait_dir_high();
        chk(req, "dir after power return", int'(dir), 1);
        chk(req, "clk_out_en before lock seen", int'(clk_out_en), 0);
        wait_clk_on();
        chk(req, "dir when clock starts", int'(dir), 1);
        measure_high(n);
        chk(req, "reset length after lock", n, N);
        check_report(req);
    endtask

    task automatic t_reset_state();
        repeat (3) @(negedge clk);
        chk("R1", "pins_oe in reset", int'(pins_oe), 0);
        chk("R1", "dir in reset", int'(dir), 0);
        chk("R1", "clk_out_en in reset", int'(clk_out_en), 0);
        chk("R1", "rst_bit in reset", int'(rst_bit), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1", "pins_oe unpowered", int'(pins_oe), 0);
        chk("R1", "rxcmd_req unpowered", int'(rxcmd_req), 0);
    endtask

    task automatic t_power_up();
        int n;
        line_state = 2'b01;
        pwr_good = 1'b1; chip_sel = 1'b1;
        repeat (SYNC + 1) @(negedge clk);
        chk("R3", "dir after power-on", int'(dir), 1);
        chk("R3", "pins_oe after power-on", int'(pins_oe), 1);
        chk("R3", "clk_out_en without lock", int'(clk_out_en), 0);
        repeat (5) @(negedge clk);
        chk("R3", "dir still held", int'(dir), 1);
        chk("R3", "clk_out_en still off", int'(clk_out_en), 0);
        pll_locked = 1'b1;
        wait_clk_on();
        chk("R4", "dir as clock starts", int'(dir), 1);
        measure_high(n);
        chk("R4", "power-on reset length", n, N);
        check_report("R7");
    endtask

    task automatic t_soft_reset();
        int n;
        line_state = 2'b10;
        write_reg(6'h04, 8'h20);
        chk("R5", "rst_bit after write", int'(rst_bit), 1);
        chk("R5", "dir one cycle after write", int'(dir), 0);
        @(negedge clk);
        chk("R5", "dir two cycles after write", int'(dir), 1);
        measure_high(n);
        chk("R5", "soft reset length", n, N);
        check_report("R7");
    endtask

    task automatic t_ignored_writes();
        write_reg(6'h04, 8'hDF);
        write_reg(6'h14, 8'h20);
        write_reg(6'h07, 8'hFF);
        for (int i = 0; i < 3; i++) begin
            chk("R9", "rst_bit after foreign write", int'(rst_bit), 0);
            chk("R9", "dir after foreign write", int'(dir), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_restart();
        int n;
        line_state = 2'b11;
        write_reg(6'h04, 8'h21);
        @(negedge clk);
        chk("R8", "dir before rewrite", int'(dir), 1);
        repeat (4) @(negedge clk);
        write_reg(6'h04, 8'h20);
        chk("R8", "rst_bit during restart", int'(rst_bit), 1);
        measure_high(n);
        chk("R8", "length after rewrite", n, N);
        check_report("R7");
    endtask

    task automatic t_power_loss();
        write_reg(6'h04, 8'h20);
        @(negedge clk);
        repeat (2) @(negedge clk);
        pwr_good = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        chk("R1", "pins_oe after supply loss", int'(pins_oe), 0);
        chk("R1", "dir after supply loss", int'(dir), 0);
        chk("R1", "clk_out_en after supply loss", int'(clk_out_en), 0);
        chk("R1", "rst_bit after supply loss", int'(rst_bit), 0);
        pwr_good = 1'b1;
        finish_power_up("R3");
    endtask

    task automatic t_chip_select_cycle();
        chip_sel = 1'b0;
        repeat (SYNC + 2) @(negedge clk);
        chk("R1", "pins_oe chip deselected", int'(pins_oe), 0);
        write_reg(6'h04, 8'h20);
        chk("R2", "rst_bit write in power-down", int'(rst_bit), 0);
        repeat (2) @(negedge clk);
        chk("R2", "rst_bit later in power-down", int'(rst_bit), 0);
        chip_sel = 1'b1;
        finish_power_up("R10");
        for (int i = 0; i < 4; i++) begin
            chk("R2", "no pending reset dir", int'(dir), 0);
            chk("R2", "no pending reset bit", int'(rst_bit), 0);
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_power_up();
        repeat (2) @(negedge clk);
        t_soft_reset();
        t_ignored_writes();
        t_restart();
        repeat (2) @(negedge clk);
        t_power_loss();
        repeat (2) @(negedge clk);
        t_chip_select_cycle();
        summary();
        $finish;
    end

endmodule